// File: doc/BRIEF.md
# Status-Flag ALU with Decimal Add

This block is the purely combinational arithmetic and logic unit of a small 16-bit microcontroller core. In one evaluation it takes a source operand, a destination operand, the incoming carry, a byte/word select and a four-bit operation code. It returns the result, a write-enable that says whether the result should be stored, and the four status flags: overflow (V), negative (N), zero (Z) and carry (C). Each flag has its own update-enable, so the core's status register changes only the flags that the operation defines.

The unit supports binary add and subtract, both with and without the incoming carry. It also has a packed-BCD add with carry, a compare that does not write its result, and the logic operations AND, bit-test, bit-clear, bit-set and XOR. The single-operand operations act on the destination operand: an arithmetic right rotate, a right rotate through carry, a byte swap and a sign extend. Operand fetch, addressing and the register file belong to the surrounding core.

Top module: `alu_flagged`

## Requirements
- R1: ADD produces dst+src and ADDC produces dst+src+carry_i. C is the carry out of the top bit and V is signed overflow. N is the result's top bit and Z is set when the result is zero. All four flags update and the result is written.
- R2: SUB produces dst + NOT(src) + 1 and SUBC produces dst + NOT(src) + carry_i. C=1 means no borrow and V is signed overflow of the subtraction. All four flags update and the result is written.
- R3: CMP updates all four flags exactly as SUB would, and its result write-enable is 0.
- R4: DADD adds src, dst and carry_i as packed BCD with one decimal digit per nibble. C is the decimal carry out of the top digit and V is cleared. N and Z follow the result, and all four flags update.
- R5: AND and BIT compute src AND dst, clear V, set C to NOT Z and update all four flags. BIT does not write its result.
- R6: XOR computes src XOR dst, sets V only when both operands are negative, sets C to NOT Z and updates all four flags.
- R7: BIC (NOT src AND dst), BIS (src OR dst) and SWAP write their result and update no flag.
- R8: RRA shifts dst right by one and keeps its top bit. The old bit 0 goes to C and V is cleared.
- R9: RRC shifts dst right by one with carry_i entering the top bit. The old bit 0 goes to C and V is cleared.
- R10: SWAP exchanges the two bytes of dst. SEXT copies dst bit 7 into bits 15..8, clears V and sets C to NOT Z. Both always work on the full word, whatever byte_i is.
- R11: With byte_i=1, every other operation works on bits 7..0 alone. Result bits 15..8 are 0, N is bit 7, Z looks at the low byte, and C and V come from bit 7.
- R12: The op_i codes are ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, DADD=5, AND=6, BIT=7, BIC=8, BIS=9, XOR=10, RRA=11, RRC=12, SWAP=13 and SEXT=14. Code 15 writes nothing and updates no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand; sole operand of single-operand ops |
| carry_i | input | 1 | Incoming carry flag |
| byte_i | input | 1 | 1 selects byte-width operation |
| op_i | input | 4 | Operation code |
| res_o | output | 16 | Result |
| res_we_o | output | 1 | Result should be stored |
| v_o | output | 1 | Overflow flag value |
| n_o | output | 1 | Negative flag value |
| z_o | output | 1 | Zero flag value |
| c_o | output | 1 | Carry flag value |
| v_we_o | output | 1 | Overflow flag update enable |
| n_we_o | output | 1 | Negative flag update enable |
| z_we_o | output | 1 | Zero flag update enable |
| c_we_o | output | 1 | Carry flag update enable |

## Verification
The hardest case to reach is the decimal carry chain: a digit that lands on exactly ten must ripple through every higher nine. The stimulus drives all-nines operands with a carry of one, in both widths. In byte mode this shows that the carry comes out of the second digit and does not reach the third. Signed overflow on subtract with an incoming carry of zero is also hard to hit. Operands just past the most negative value are chosen so that the borrow alone decides V.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W  = 16;
  localparam int unsigned BYTE_W = ALU_W / 2;

  typedef logic [ALU_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_CMP  = 4'd4,
    OP_DADD = 4'd5,
    OP_AND  = 4'd6,
    OP_BIT  = 4'd7,
    OP_BIC  = 4'd8,
    OP_BIS  = 4'd9,
    OP_XOR  = 4'd10,
    OP_RRA  = 4'd11,
    OP_RRC  = 4'd12,
    OP_SWAP = 4'd13,
    OP_SEXT = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  // Clip a word to the active width: the upper byte is zero in byte mode.
  function automatic word_t fit(word_t x, logic bmode);
    return bmode ? {{(ALU_W-BYTE_W){1'b0}}, x[BYTE_W-1:0]} : x;
  endfunction

  // Sign bit of the active width.
  function automatic logic msb_of(word_t x, logic bmode);
    return bmode ? x[BYTE_W-1] : x[ALU_W-1];
  endfunction

  // Zero test over the active width.
  function automatic logic is_zero(word_t x, logic bmode);
    return bmode ? (x[BYTE_W-1:0] == '0) : (x == '0);
  endfunction

  // The byte-swap and sign-extend operations ignore the byte select.
  function automatic logic word_only(alu_op_e op);
    return (op == OP_SWAP) || (op == OP_SEXT);
  endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          inv_b_i,
  input  logic          cin_i,
  input  logic          bmode_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic [DW:0]   full_sum;
  logic [HW:0]   half_sum;
  logic          a_top, b_top, s_top;

  assign b_eff    = inv_b_i ? ~b_i : b_i;
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
  assign half_sum = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin_i};

  assign sum_o  = bmode_i ? {{(DW-HW){1'b0}}, half_sum[HW-1:0]} : full_sum[DW-1:0];
  assign cout_o = bmode_i ? half_sum[HW] : full_sum[DW];

  assign a_top = bmode_i ? a_i[HW-1]   : a_i[DW-1];
  assign b_top = bmode_i ? b_eff[HW-1] : b_eff[DW-1];
  assign s_top = bmode_i ? half_sum[HW-1] : full_sum[DW-1];

  // Overflow: both addends share a sign that the sum does not.
  assign ovf_o = (a_top == b_top) && (s_top != a_top);
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          bmode_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);
  localparam int unsigned ND = DW / 4;
  localparam int unsigned NB = ND / 2;
  localparam int unsigned HW = DW / 2;

  logic [ND:0]   dig_cy;
  logic [DW-1:0] dig_sum;

  assign dig_cy[0] = cin_i;

  for (genvar d = 0; d < ND; d++) begin : g_digit
    logic [4:0] raw;
    logic       adj;
    assign raw = {1'b0, a_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]} + {4'b0000, dig_cy[d]};
    assign adj = (raw > 5'd9);
    assign dig_sum[4*d +: 4] = adj ? (raw[3:0] + 4'd6) : raw[3:0];
    assign dig_cy[d+1] = adj;
  end

  assign sum_o  = bmode_i ? {{(DW-HW){1'b0}}, dig_sum[HW-1:0]} : dig_sum;
  assign cout_o = bmode_i ? dig_cy[NB] : dig_cy[ND];
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] x_i,
  input  logic          cin_i,
  input  logic          bmode_i,
  output logic [DW-1:0] rra_o,
  output logic [DW-1:0] rrc_o,
  output logic [DW-1:0] swap_o,
  output logic [DW-1:0] sext_o,
  output logic          lsb_o
);
  localparam int unsigned HW = DW / 2;

  logic [HW-1:0] lo;
  logic [DW-1:0] word_rra, word_rrc;
  logic [HW-1:0] byte_rra, byte_rrc;

  assign lo       = x_i[HW-1:0];
  assign word_rra = {x_i[DW-1], x_i[DW-1:1]};
  assign word_rrc = {cin_i, x_i[DW-1:1]};
  assign byte_rra = {lo[HW-1], lo[HW-1:1]};
  assign byte_rrc = {cin_i, lo[HW-1:1]};

  assign rra_o  = bmode_i ? {{(DW-HW){1'b0}}, byte_rra} : word_rra;
  assign rrc_o  = bmode_i ? {{(DW-HW){1'b0}}, byte_rrc} : word_rrc;
  assign swap_o = {lo, x_i[DW-1:HW]};
  assign sext_o = {{(DW-HW){lo[HW-1]}}, lo};
  assign lsb_o  = x_i[0];
endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
  import alu_pkg::*;
(
  input  logic [15:0] src_i,
  input  logic [15:0] dst_i,
  input  logic        carry_i,
  input  logic        byte_i,
  input  logic [3:0]  op_i,
  output logic [15:0] res_o,
  output logic        res_we_o,
  output logic        v_o,
  output logic        n_o,
  output logic        z_o,
  output logic        c_o,
  output logic        v_we_o,
  output logic        n_we_o,
  output logic        z_we_o,
  output logic        c_we_o
);
  alu_op_e op;
  logic    eff_byte;

  assign op       = alu_op_e'(op_i);
  assign eff_byte = byte_i && !word_only(op);

  // Adder control: subtract forms invert the source.
  logic  add_inv, add_cin;
  word_t add_sum;
  logic  add_cout, add_ovf;

  always_comb begin
    add_inv = 1'b0;
    add_cin = 1'b0;
    unique case (op)
      OP_ADDC:        add_cin = carry_i;
      OP_SUB, OP_CMP: begin add_inv = 1'b1; add_cin = 1'b1; end
      OP_SUBC:        begin add_inv = 1'b1; add_cin = carry_i; end
      default: ;
    endcase
  end

  alu_addsub #(.DW(ALU_W)) i_addsub (
    .a_i     (dst_i),
    .b_i     (src_i),
    .inv_b_i (add_inv),
    .cin_i   (add_cin),
    .bmode_i (eff_byte),
    .sum_o   (add_sum),
    .cout_o  (add_cout),
    .ovf_o   (add_ovf)
  );

  word_t bcd_sum;
  logic  bcd_cout;

  alu_bcd #(.DW(ALU_W)) i_bcd (
    .a_i     (dst_i),
    .b_i     (src_i),
    .cin_i   (carry_i),
    .bmode_i (eff_byte),
    .sum_o   (bcd_sum),
    .cout_o  (bcd_cout)
  );

  word_t sh_rra, sh_rrc, sh_swap, sh_sext;
  logic  sh_lsb;

  alu_shift #(.DW(ALU_W)) i_shift (
    .x_i     (dst_i),
    .cin_i   (carry_i),
    .bmode_i (eff_byte),
    .rra_o   (sh_rra),
    .rrc_o   (sh_rrc),
    .swap_o  (sh_swap),
    .sext_o  (sh_sext),
    .lsb_o   (sh_lsb)
  );

  word_t and_res, bic_res, bis_res, xor_res;
  logic  both_neg;

  assign and_res  = fit(src_i & dst_i, eff_byte);
  assign bic_res  = fit(~src_i & dst_i, eff_byte);
  assign bis_res  = fit(src_i | dst_i, eff_byte);
  assign xor_res  = fit(src_i ^ dst_i, eff_byte);
  assign both_neg = msb_of(src_i, eff_byte) && msb_of(dst_i, eff_byte);

  // Result selection and write enable.
  word_t res_w;
  logic  we_w;

  always_comb begin
    res_w = '0;
    we_w  = 1'b1;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: res_w = add_sum;
      OP_CMP:  begin res_w = add_sum; we_w = 1'b0; end
      OP_DADD: res_w = bcd_sum;
      OP_AND:  res_w = and_res;
      OP_BIT:  begin res_w = and_res; we_w = 1'b0; end
      OP_BIC:  res_w = bic_res;
      OP_BIS:  res_w = bis_res;
      OP_XOR:  res_w = xor_res;
      OP_RRA:  res_w = sh_rra;
      OP_RRC:  res_w = sh_rrc;
      OP_SWAP: res_w = sh_swap;
      OP_SEXT: res_w = sh_sext;
      default: we_w = 1'b0;
    endcase
  end

  // Flags derived from the selected result.
  logic res_neg, res_zero;
  assign res_neg  = msb_of(res_w, eff_byte);
  assign res_zero = is_zero(res_w, eff_byte);

  logic v_w, c_w, flags_upd;

  always_comb begin
    v_w       = 1'b0;
    c_w       = 1'b0;
    flags_upd = 1'b1;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        v_w = add_ovf;
        c_w = add_cout;
      end
      OP_DADD:        c_w = bcd_cout;
      OP_AND, OP_BIT: c_w = !res_zero;
      OP_XOR: begin
        v_w = both_neg;
        c_w = !res_zero;
      end
      OP_RRA, OP_RRC: c_w = sh_lsb;
      OP_SEXT:        c_w = !res_zero;
      default:        flags_upd = 1'b0;
    endcase
  end

  assign res_o    = res_w;
  assign res_we_o = we_w;
  assign v_o      = flags_upd & v_w;
  assign n_o      = flags_upd & res_neg;
  assign z_o      = flags_upd & res_zero;
  assign c_o      = flags_upd & c_w;
  assign v_we_o   = flags_upd;
  assign n_we_o   = flags_upd;
  assign z_we_o   = flags_upd;
  assign c_we_o   = flags_upd;
endmodule

// File: rtl/alu_flagged_chk.sv
module alu_flagged_chk (
  input logic [15:0] src_i,
  input logic [15:0] dst_i,
  input logic        byte_i,
  input logic [3:0]  op_i,
  input logic [15:0] res_o,
  input logic        res_we_o,
  input logic        v_o,
  input logic        z_o,
  input logic        c_o,
  input logic        v_we_o,
  input logic        n_we_o,
  input logic        z_we_o,
  input logic        c_we_o
);
  logic any_flag;
  assign any_flag = v_we_o | n_we_o | z_we_o | c_we_o;

  always_comb begin
    if (op_i == 4'd4)
      AST_CMP_NO_WRITE: assert (!res_we_o && v_we_o && c_we_o) else $error("compare wrote"); // R3
    if (op_i == 4'd7)
      AST_BIT_NO_WRITE: assert (!res_we_o) else $error("bit-test wrote"); // R5
    if (op_i == 4'd6 || op_i == 4'd7)
      AST_LOGIC_V_CLEAR: assert (v_we_o && !v_o && (c_o == !z_o)) else $error("logic flags"); // R5
    if (op_i == 4'd10)
      AST_XOR_V_RULE: assert (v_o == (byte_i ? (src_i[7] & dst_i[7]) : (src_i[15] & dst_i[15])))
        else $error("xor overflow"); // R6
    if (op_i == 4'd8 || op_i == 4'd9 || op_i == 4'd13)
      AST_QUIET_FLAGS: assert (!any_flag && res_we_o) else $error("flags touched"); // R7
    if (op_i == 4'd11)
      AST_RRA_KEEP_MSB: assert (byte_i ? (res_o[7] == dst_i[7]) : (res_o[15] == dst_i[15]))
        else $error("rra msb"); // R8
    if (op_i == 4'd14)
      AST_SEXT_UPPER: assert (res_o[15:8] == {8{dst_i[7]}} && !v_o) else $error("sext"); // R10
    if (byte_i && op_i != 4'd13 && op_i != 4'd14)
      AST_BYTE_UPPER_ZERO: assert (res_o[15:8] == 8'h00) else $error("byte upper"); // R11
    if (op_i == 4'd15)
      AST_RESERVED_IDLE: assert (!res_we_o && !any_flag) else $error("reserved active"); // R12
  end
endmodule

bind alu_flagged alu_flagged_chk i_chk (
  .src_i    (src_i),
  .dst_i    (dst_i),
  .byte_i   (byte_i),
  .op_i     (op_i),
  .res_o    (res_o),
  .res_we_o (res_we_o),
  .v_o      (v_o),
  .z_o      (z_o),
  .c_o      (c_o),
  .v_we_o   (v_we_o),
  .n_we_o   (n_we_o),
  .z_we_o   (z_we_o),
  .c_we_o   (c_we_o)
);

// File: tb/test_alu_flagged.sv
module test_alu_flagged;
  localparam logic [3:0] ADD = 0, ADDC = 1, SUB = 2, SUBC = 3, CMP = 4, DADD = 5,
                         AND_ = 6, BIT = 7, BIC = 8, BIS = 9, XOR_ = 10, RRA = 11,
                         RRC = 12, SWAP = 13, SEXT = 14, NONE = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] src, dst, res;
  logic        cin, bsel, we, v, n, z, c, vwe, nwe, zwe, cwe;
  logic [3:0]  op;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_flagged i_alu_flagged (
    .src_i(src), .dst_i(dst), .carry_i(cin), .byte_i(bsel), .op_i(op),
    .res_o(res), .res_we_o(we), .v_o(v), .n_o(n), .z_o(z), .c_o(c),
    .v_we_o(vwe), .n_we_o(nwe), .z_we_o(zwe), .c_we_o(cwe)
  );

  function automatic int sx(int val, int w);
    return (val >= (1 << (w - 1))) ? val - (1 << w) : val;
  endfunction

  // Independent reference built from the requirement text.
  task automatic model(input logic [3:0] o, input int s, input int d, input int ci, input bit b,
                       output int r, output bit rwe, output bit fe, output bit [3:0] fl);
    int w, m, a, x, t, sv, nd, lim, da, db, sm, p;
    bit vf, cf, wide;
    wide = (o == SWAP) || (o == SEXT);
    w  = (b && !wide) ? 8 : 16;
    m  = (1 << w) - 1;
    a  = d & m;
    x  = s & m;
    r  = 0; rwe = 1; fe = 1; vf = 0; cf = 0;
    case (o)
      ADD, ADDC: begin
        t  = a + x + ((o == ADDC) ? ci : 0);
        sv = sx(a, w) + sx(x, w) + ((o == ADDC) ? ci : 0);
        r = t & m; cf = t[w];
        vf = (sv > (1 << (w - 1)) - 1) || (sv < -(1 << (w - 1)));
      end
      SUB, SUBC, CMP: begin
        t  = a + ((~x) & m) + ((o == SUBC) ? ci : 1);
        sv = sx(a, w) - sx(x, w) - 1 + ((o == SUBC) ? ci : 1);
        r = t & m; cf = t[w];
        vf = (sv > (1 << (w - 1)) - 1) || (sv < -(1 << (w - 1)));
        rwe = (o != CMP);
      end
      DADD: begin
        nd = w / 4; lim = 1; da = 0; db = 0; p = 1;
        for (int k = 0; k < nd; k++) begin
          da += ((a >> (4 * k)) & 15) * p;
          db += ((x >> (4 * k)) & 15) * p;
          p *= 10;
        end
        lim = p;
        sm = da + db + ci;
        cf = (sm >= lim);
        sm = sm % lim;
        for (int k = 0; k < nd; k++) begin
          r |= (sm % 10) << (4 * k);
          sm /= 10;
        end
      end
      AND_, BIT: begin r = a & x; rwe = (o != BIT); cf = (r != 0); end
      XOR_: begin r = a ^ x; cf = (r != 0); vf = a[w-1] && x[w-1]; end
      BIC: begin r = (~x) & a & m; fe = 0; end
      BIS: begin r = a | x; fe = 0; end
      RRA: begin r = (a >> 1) | (a & (1 << (w - 1))); cf = a[0]; end
      RRC: begin r = (a >> 1) | (ci << (w - 1)); cf = a[0]; end
      SWAP: begin r = ((a & 255) << 8) | (a >> 8); fe = 0; end
      SEXT: begin r = a[7] ? ((a & 255) | 16'hFF00) : (a & 255); cf = (r != 0); end
      default: begin rwe = 0; fe = 0; end
    endcase
    fl = {vf, bit'((r >> (w - 1)) & 1), bit'(r == 0), cf};
  endtask

  task automatic drive(input logic [3:0] o, input logic [15:0] s, input logic [15:0] d,
                       input logic ci, input logic b);
    @(posedge clk); #1;
    op = o; src = s; dst = d; cin = ci; bsel = b;
    #4;
  endtask

  task automatic expect_out(input string tag, input int er, input bit ewe, input bit efe,
                            input bit [3:0] efl);
    bit bad;
    checks++;
    bad = (int'(res) != er) || (we != ewe) || ({vwe, nwe, zwe, cwe} != {4{efe}});
    if (efe && ({v, n, z, c} != efl)) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s: got res=%h we=%b en=%b vnzc=%b, expected res=%h we=%b en=%b vnzc=%b",
               tag, res, we, {vwe, nwe, zwe, cwe}, {v, n, z, c}, er[15:0], ewe, {4{efe}}, efl);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic [15:0] s,
                     input logic [15:0] d, input logic ci, input logic b);
    int er; bit ewe, efe; bit [3:0] efl;
    drive(o, s, d, ci, b);
    model(o, int'(s), int'(d), int'(ci), b, er, ewe, efe, efl);
    expect_out(tag, er, ewe, efe, efl);
  endtask

  task automatic t_reset;
    drive(ADD, 16'h0000, 16'h0000, 1'b0, 1'b0);
    expect_out("R1 reset zero", 0, 1, 1, 4'b0010);
  endtask

  task automatic t_add;
    run("R1 add plain", ADD, 16'h1234, 16'h0F0F, 0, 0);
    run("R1 add signed ovf", ADD, 16'h7FFF, 16'h0001, 0, 0);
    run("R1 add carry out", ADD, 16'hFFFF, 16'h0001, 0, 0);
    run("R1 addc", ADDC, 16'h00FF, 16'h0100, 1, 0);
    drive(ADD, 16'h8000, 16'h8000, 0, 0);
    expect_out("R1 add fixed", 0, 1, 1, 4'b1011);
  endtask

  task automatic t_sub;
    run("R2 sub", SUB, 16'h0003, 16'h0005, 0, 0);
    run("R2 sub borrow", SUB, 16'h0005, 16'h0003, 0, 0);
    run("R2 subc c0 ovf", SUBC, 16'h0000, 16'h8000, 0, 0);
    run("R2 subc c1", SUBC, 16'h0001, 16'h8001, 1, 0);
    drive(SUB, 16'h0001, 16'h8000, 0, 0);
    expect_out("R2 sub fixed", 16'h7FFF, 1, 1, 4'b1001);
  endtask

  task automatic t_cmp;
    run("R3 cmp equal", CMP, 16'h4444, 16'h4444, 0, 0);
    run("R3 cmp less", CMP, 16'h0010, 16'h0002, 1, 0);
  endtask

  task automatic t_dadd;
    run("R4 dadd", DADD, 16'h0999, 16'h0001, 0, 0);
    run("R4 dadd ripple", DADD, 16'h9999, 16'h0000, 1, 0);
    drive(DADD, 16'h0999, 16'h0001, 0, 0);
    expect_out("R4 dadd fixed", 16'h1000, 1, 1, 4'b0000);
    drive(DADD, 16'h0099, 16'h0000, 1, 1);
    expect_out("R4 R11 dadd byte ripple", 0, 1, 1, 4'b0011);
  endtask

  task automatic t_logic;
    run("R5 and", AND_, 16'hF0F0, 16'h8F00, 0, 0);
    run("R5 and zero", AND_, 16'h00FF, 16'hFF00, 1, 0);
    run("R5 bit", BIT, 16'h0080, 16'h0081, 0, 0);
    run("R6 xor both neg", XOR_, 16'h8001, 16'h8003, 0, 0);
    run("R6 xor one neg", XOR_, 16'h8001, 16'h0001, 0, 0);
    run("R6 R11 xor byte", XOR_, 16'h0080, 16'h8080, 0, 1);
  endtask

  task automatic t_quiet;
    run("R7 bic", BIC, 16'h0F0F, 16'hFFFF, 1, 0);
    run("R7 bis", BIS, 16'h1000, 16'h0001, 0, 0);
    run("R7 R10 swap", SWAP, 16'h0000, 16'hAB12, 0, 1);
  endtask

  task automatic t_shift;
    run("R8 rra", RRA, 16'h0000, 16'h8003, 0, 0);
    run("R8 R11 rra byte", RRA, 16'h0000, 16'h7F81, 1, 1);
    run("R9 rrc", RRC, 16'h0000, 16'h0002, 1, 0);
    run("R9 R11 rrc byte", RRC, 16'h0000, 16'hFF01, 1, 1);
    run("R10 sext neg", SEXT, 16'h0000, 16'h1280, 0, 1);
    run("R10 sext pos", SEXT, 16'h0000, 16'hFF7F, 0, 0);
    drive(SEXT, 16'h0000, 16'hAA00, 0, 0);
    expect_out("R10 sext zero", 0, 1, 1, 4'b0010);
  endtask

  task automatic t_byte;
    run("R11 add byte", ADD, 16'h12FF, 16'h3401, 0, 1);
    run("R11 sub byte ovf", SUB, 16'hFF01, 16'h0080, 0, 1);
    run("R11 and byte", AND_, 16'hFF80, 16'hFF80, 0, 1);
    run("R11 bis byte", BIS, 16'hAA01, 16'h5502, 0, 1);
  endtask

  task automatic t_reserved;
    drive(NONE, 16'hFFFF, 16'hFFFF, 1, 0);
    expect_out("R12 reserved", 0, 0, 0, 4'b0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    op = NONE; src = '0; dst = '0; cin = 0; bsel = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset;
    t_add;
    t_sub;
    t_cmp;
    t_dadd;
    t_logic;
    t_quiet;
    t_shift;
    t_byte;
    t_reserved;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule